// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is a slave serial port that gives an external host read and write access to a small byte-wide register map. It has three pins: an active-low select, a serial clock and a single data line. The data line is an input while the host sends and becomes an output while the block returns readback. All pins are sampled by the block's own system clock through synchronizers. The serial clock must therefore run well below the system clock (each half period at least six system cycles).

A frame is a 16-bit instruction followed by one or more data bytes. The instruction is always sent most significant bit first. Its bit 15 selects read (1) or write (0). Bits 14:13 hold a byte-count code. Bits 12:0 hold the start register address. The address moves up by one after every data byte. The select line may be raised at a byte boundary to pause a transfer. It may also be held low for an open-ended streaming transfer.

If the select line is high from reset onward, the port stays disabled. In that state the clock and data pins act as plain static control levels. The first low level on the select line turns the port on for good, until the next reset. Register 0 is the configuration register, and its bit 0 picks the data bit order.

Top module: `spi3_cfg_port`

## Requirements
- R1: While select has stayed high since reset, pin_ctrl_mode_o is 1, pin_ctrl_o[0] follows sclk_i, pin_ctrl_o[1] follows sdio_i, sdio_oe_o is 0 and no register is written. After reset every register reads 0.
- R2: The first low level on cs_ni clears pin_ctrl_mode_o. It stays 0, with pin_ctrl_o at 0, until the next reset, whatever the select and clock levels do afterwards.
- R3: Data-line bits are sampled on rising serial-clock edges. The instruction is 16 bits, most significant bit first. Bit 15 = 1 means read and 0 means write, bits 14:13 are the count code, and bits 12:0 are the start address.
- R4: Count codes 00, 01 and 10 transfer exactly 1, 2 and 3 bytes at consecutive addresses. Bytes clocked after the count has been reached are ignored: no write, and the data line is not driven.
- R5: Count code 11 streams. Bytes keep flowing at consecutive addresses until the select line rises.
- R6: In a write frame, each complete data byte is stored in the addressed register and is visible on regs_o, at bits 8*addr+7 to 8*addr.
- R7: In a read frame, sdio_oe_o is 0 during the instruction. It is 1 from the first low clock phase after the instruction. Readback bits change only after falling clock edges. sdio_oe_o returns to 0 when the frame's byte count is complete or when the select line rises.
- R8: Bit 0 of register 0 sets the bit order of data bytes: 0 (the reset value) means most significant bit first and 1 means least significant bit first. It applies to both directions, from the byte after the one that changed it.
- R9: A select-high pause at a byte boundary, with bytes still due, keeps the address and the byte count. The next low level resumes the same frame.
- R10: A select rise in the middle of a byte aborts the frame. The partial byte is not written, and the next low level starts a new instruction.
- R11: Addresses at or above NUM_REGS read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, readback value |
| sdio_oe_o | output | 1 | Data line output enable |
| regs_o | output | NUM_REGS*8 | Register contents, register n at bits 8n+7:8n |
| pin_ctrl_mode_o | output | 1 | 1 while the port is disabled by the power-up select level |
| pin_ctrl_o | output | 2 | Static control levels: bit 0 from the clock pin, bit 1 from the data pin |

## Verification
The hardest states to reach are the frame states that lie between two bytes. One is a read that was paused with the select line and then resumed, where the first readback bit has to appear before any falling clock edge. Another is an abort that hits in the middle of an instruction or a data byte. Directed frames place select rises at exact bit counts to produce these, and also to change the bit order in the middle of a session. A seeded random loop of reads and writes with random counts, addresses and streaming lengths then checks every readback against a bench register model.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int INSTR_BITS = 16;
  localparam int ADDR_W     = 13;
  localparam int CFG_LSB_BIT = 0;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_INSTR,
    PH_DATA,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic              rd;
    logic [1:0]        cnt;
    logic [ADDR_W-1:0] addr;
  } instr_t;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi3_strap.sv
module spi3_strap (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_low_i,
  input  logic       sclk_i,
  input  logic       sdio_i,
  output logic       mode_o,
  output logic [1:0] ctrl_o
);
  logic port_en_q;

  // sticky: one low select level enables the port until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       port_en_q <= 1'b0;
    else if (cs_low_i) port_en_q <= 1'b1;
  end

  assign mode_o = ~port_en_q;
  assign ctrl_o = mode_o ? {sdio_i, sclk_i} : 2'b00;
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 13,
  parameter int LSB_BIT  = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic                  lsb_first_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     regs_q[g] <= 8'h00;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))     regs_q[g] <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = regs_q[g];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = regs_q[i];
  end

  assign lsb_first_o = regs_q[0][LSB_BIT];
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_low_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  input  logic              lsb_first_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [7:0]        wr_data_o,
  output logic              sdio_o,
  output logic              sdio_oe_o
);
  phase_e            phase_q;
  logic [3:0]        bit_cnt_q;
  logic [INSTR_BITS-1:0] instr_sh_q;
  logic [7:0]        rx_sh_q;
  logic              rd_q, stream_q;
  logic [1:0]        remain_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sclk_prev_q;
  logic              oe_q, out_q;

  logic              sclk_rise, sclk_fall;
  instr_t            instr_nxt;
  logic [7:0]        rx_nxt;
  logic [2:0]        tx_idx;
  logic              byte_end;

  assign sclk_rise = sclk_i & ~sclk_prev_q;
  assign sclk_fall = ~sclk_i & sclk_prev_q;
  assign instr_nxt = instr_t'({instr_sh_q[INSTR_BITS-2:0], sdio_i});
  assign rx_nxt    = lsb_first_i ? {sdio_i, rx_sh_q[7:1]} : {rx_sh_q[6:0], sdio_i};
  assign tx_idx    = lsb_first_i ? bit_cnt_q[2:0] : 3'd7 - bit_cnt_q[2:0];
  assign byte_end  = cs_low_i && sclk_rise && phase_q == PH_DATA && bit_cnt_q == 4'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_cnt_q  <= '0;
      instr_sh_q <= '0;
      rx_sh_q    <= '0;
      rd_q       <= 1'b0;
      stream_q   <= 1'b0;
      remain_q   <= '0;
      addr_q     <= '0;
    end else if (!cs_low_i) begin
      // pause only at a byte boundary with bytes still due
      unique case (phase_q)
        PH_DONE:  phase_q <= PH_IDLE;
        PH_INSTR: if (bit_cnt_q[2:0] != 3'd0) phase_q <= PH_IDLE;
        PH_DATA:  if (bit_cnt_q != 4'd0 || stream_q) phase_q <= PH_IDLE;
        default: ;
      endcase
    end else if (phase_q == PH_IDLE) begin
      phase_q   <= PH_INSTR;
      bit_cnt_q <= '0;
    end else if (sclk_rise) begin
      unique case (phase_q)
        PH_INSTR: begin
          instr_sh_q <= instr_nxt;
          bit_cnt_q  <= bit_cnt_q + 4'd1;
          if (bit_cnt_q == 4'd15) begin
            phase_q   <= PH_DATA;
            bit_cnt_q <= '0;
            rd_q      <= instr_nxt.rd;
            stream_q  <= &instr_nxt.cnt;
            remain_q  <= instr_nxt.cnt;
            addr_q    <= instr_nxt.addr;
          end
        end
        PH_DATA: begin
          rx_sh_q   <= rx_nxt;
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (bit_cnt_q == 4'd7) begin
            bit_cnt_q <= '0;
            addr_q    <= addr_q + 1'b1;
            if (!stream_q) begin
              if (remain_q == 2'd0) phase_q <= PH_DONE;
              else                  remain_q <= remain_q - 2'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // readback driver: update after falling edges, or at once while clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
    end else if (!cs_low_i || phase_q != PH_DATA || !rd_q) begin
      oe_q <= 1'b0;
    end else if (sclk_fall || (!oe_q && !sclk_i)) begin
      oe_q  <= 1'b1;
      out_q <= rd_data_i[tx_idx];
    end
  end

  assign addr_o    = addr_q;
  assign wr_en_o   = byte_end && !rd_q;
  assign wr_data_o = rx_nxt;
  assign sdio_o    = out_q;
  assign sdio_oe_o = oe_q;
endmodule

// File: rtl/spi3_cfg_port.sv
module spi3_cfg_port
  import spi3_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sclk_i,
  input  logic                  sdio_i,
  output logic                  sdio_o,
  output logic                  sdio_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  pin_ctrl_mode_o,
  output logic [1:0]            pin_ctrl_o
);
  localparam int PINS = 3;

  logic [PINS-1:0]   pins_s;
  logic              cs_low_s, sclk_s, sdio_s;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [7:0]        wr_data, rd_data;
  logic              lsb_first;

  spi3_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdio_i, sclk_i, cs_ni}),
    .q_o   (pins_s)
  );

  assign cs_low_s = ~pins_s[0];
  assign sclk_s   = pins_s[1];
  assign sdio_s   = pins_s[2];

  spi3_strap u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_low_i(cs_low_s),
    .sclk_i  (sclk_s),
    .sdio_i  (sdio_s),
    .mode_o  (pin_ctrl_mode_o),
    .ctrl_o  (pin_ctrl_o)
  );

  spi3_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_low_i   (cs_low_s),
    .sclk_i     (sclk_s),
    .sdio_i     (sdio_s),
    .lsb_first_i(lsb_first),
    .rd_data_i  (rd_data),
    .addr_o     (addr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sdio_o     (sdio_o),
    .sdio_oe_o  (sdio_oe_o)
  );

  spi3_regfile #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W),
    .LSB_BIT (CFG_LSB_BIT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (addr),
    .rd_data_o  (rd_data),
    .lsb_first_o(lsb_first),
    .regs_o     (regs_o)
  );
endmodule

// File: rtl/spi3_cfg_port_chk.sv
module spi3_cfg_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_low_i,
  input logic sdio_oe_i,
  input logic mode_i,
  input logic wr_en_i
);
  // R7: select high releases the data line on the next cycle
  p_oe_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_low_i |=> !sdio_oe_i);

  // R2: once enabled the port never returns to static-pin mode
  p_strap_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> !mode_i);

  // R1: disabled port neither drives nor writes
  p_strap_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> (!sdio_oe_i && !wr_en_i));

  // R6: writes happen only inside a selected write frame
  p_wr_in_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (cs_low_i && !sdio_oe_i));
endmodule

bind spi3_cfg_port spi3_cfg_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_low_i (cs_low_s),
  .sdio_oe_i(sdio_oe_o),
  .mode_i   (pin_ctrl_mode_o),
  .wr_en_i  (wr_en)
);

// File: tb/sim_spi3_cfg_port.sv
module sim_spi3_cfg_port;
  localparam int NR = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio = 1'b0;
  logic sdio_o, sdio_oe;
  logic [NR*8-1:0] regs;
  logic pmode;
  logic [1:0] pctrl;

  int checks = 0, errors = 0;
  logic [7:0] mdl [NR];
  logic [7:0] wdat [16];
  logic [7:0] rdat [16];

  always #5 clk = ~clk;

  spi3_cfg_port #(.NUM_REGS(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdio_i(sdio),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .regs_o(regs),
    .pin_ctrl_mode_o(pmode), .pin_ctrl_o(pctrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    return (a < NR) ? mdl[a] : 8'h00;
  endfunction

  task automatic bitx(input logic b, output logic ob, output logic oe);
    sdio = b;
    tick(8);
    ob = sdio_o; oe = sdio_oe;
    sclk = 1'b1;
    tick(8);
    sclk = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] d, input logic lsb, output logic [7:0] r,
                        output logic oe_all, output logic oe_any);
    logic ob, oe;
    oe_all = 1'b1; oe_any = 1'b0; r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      bitx(d[idx], ob, oe);
      r[idx] = ob; oe_all &= oe; oe_any |= oe;
    end
  endtask

  task automatic sel_low();  cs_n = 1'b0; tick(8); endtask
  task automatic sel_high(); tick(8); cs_n = 1'b1; tick(8); endtask

  task automatic send_instr(input logic rd, input logic [1:0] code, input int addr,
                            output logic oe_any);
    logic [15:0] ins;
    logic [7:0] r;
    logic a, b;
    ins = {rd, code, 13'(addr)};
    byte_x(ins[15:8], 1'b0, r, a, b); oe_any = b;
    byte_x(ins[7:0], 1'b0, r, a, b);  oe_any |= b;
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NR; i++) chk(req, regs[i*8 +: 8], mdl[i]);
  endtask

  // n bytes clocked; stall before byte index stall (-1 none)
  task automatic do_write(input string req, input int addr, input logic [1:0] code,
                          input int n, input int stall);
    logic [7:0] r;
    logic a, b;
    sel_low();
    send_instr(1'b0, code, addr, b);
    for (int k = 0; k < n; k++) begin
      if (k == stall) begin sel_high(); tick(12); sel_low(); end
      byte_x(wdat[k], mdl[0][0], r, a, b);
      chk({req, " R7 no drive on write"}, b, 1'b0);
      if ((code == 2'd3 || k <= int'(code)) && addr + k < NR) mdl[addr + k] = wdat[k];
    end
    sel_high();
    chk_regs(req);
  endtask

  task automatic do_read(input string req, input int addr, input logic [1:0] code,
                         input int n, input int stall);
    logic [7:0] r;
    logic a, b;
    sel_low();
    send_instr(1'b1, code, addr, b);
    chk("R7 released in instruction", b, 1'b0);
    for (int k = 0; k < n; k++) begin
      if (k == stall) begin sel_high(); tick(12); sel_low(); end
      byte_x(8'h00, mdl[0][0], r, a, b);
      if (code == 2'd3 || k <= int'(code)) begin
        chk(req, r, exp_rd(addr + k));
        chk("R7 driven through byte", a, 1'b1);
      end else begin
        chk("R4 no drive past count", b, 1'b0);
      end
    end
    tick(8);
    if (code != 2'd3) chk("R7 released at count end", sdio_oe, 1'b0);
    sel_high();
    chk("R7 released at select high", sdio_oe, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic a, b;
    int seed;
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    // R1 static pin mode
    chk("R1 mode", pmode, 1'b1);
    chk("R1 oe", sdio_oe, 1'b0);
    chk_regs("R1 reset regs");
    sclk = 1'b1; sdio = 1'b0; tick(5);
    chk("R1 pin_ctrl", pctrl, 2'b01);
    sclk = 1'b0; sdio = 1'b1; tick(5);
    chk("R1 pin_ctrl", pctrl, 2'b10);
    sdio = 1'b0;
    // R2 enable is sticky
    cs_n = 1'b0; tick(6);
    chk("R2 mode cleared", pmode, 1'b0);
    cs_n = 1'b1; sclk = 1'b1; sdio = 1'b1; tick(6);
    chk("R2 mode stays", pmode, 1'b0);
    chk("R2 pin_ctrl zero", pctrl, 2'b00);
    sclk = 1'b0; sdio = 1'b0; tick(8);

    // R3 R6 single write
    wdat[0] = 8'h5A;
    do_write("R3 R6 single write", 2, 2'd0, 1, -1);
    // R4 two-byte count, third byte ignored
    wdat[0] = 8'h3C; wdat[1] = 8'hE1; wdat[2] = 8'h99;
    do_write("R4 count 01 write", 3, 2'd1, 3, -1);
    // R5 stream past the map end (R11)
    for (int k = 0; k < 5; k++) wdat[k] = 8'h10 + 8'(k * 17);
    do_write("R5 R11 stream write", 4, 2'd3, 5, -1);
    // R4 three-byte read with an extra byte clocked
    do_read("R4 count 10 read", 2, 2'd2, 4, -1);
    // R5 R11 stream read crossing the map end
    do_read("R5 R11 stream read", 6, 2'd3, 3, -1);
    // R11 out-of-range write and read
    wdat[0] = 8'hFF;
    do_write("R11 high address write", 100, 2'd0, 1, -1);
    do_read("R11 high address read", 9, 2'd0, 1, -1);

    // R8 bit order switch
    wdat[0] = 8'h01;
    do_write("R8 set lsb first", 0, 2'd0, 1, -1);
    wdat[0] = 8'hC3;
    do_write("R8 lsb write", 5, 2'd0, 1, -1);
    do_read("R8 lsb read", 0, 2'd1, 2, -1);
    do_read("R8 lsb read", 5, 2'd0, 1, -1);
    wdat[0] = 8'h00;
    do_write("R8 back to msb first", 0, 2'd0, 1, -1);
    do_read("R8 msb read", 5, 2'd0, 1, -1);

    // R9 pauses between bytes
    wdat[0] = 8'hA7; wdat[1] = 8'h6B;
    do_write("R9 paused write", 1, 2'd1, 2, 1);
    do_read("R9 paused read", 1, 2'd2, 3, 1);
    do_read("R9 pause before first data byte", 2, 2'd0, 1, 0);

    // R10 abort mid data byte
    sel_low();
    send_instr(1'b0, 2'd0, 5, b);
    for (int i = 0; i < 4; i++) bitx(1'b1, a, b);
    sel_high();
    chk_regs("R10 partial byte dropped");
    // R10 abort mid instruction, then a clean frame
    sel_low();
    for (int i = 0; i < 5; i++) bitx(1'b1, a, b);
    sel_high();
    wdat[0] = 8'h77;
    do_write("R10 new frame after abort", 5, 2'd0, 1, -1);

    // random traffic
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int it = 0; it < 40; it++) begin
      int addr, n;
      logic [1:0] code;
      addr = 1 + int'($urandom % 10);
      code = 2'($urandom % 4);
      n = (code == 2'd3) ? 1 + int'($urandom % 4) : int'(code) + 1 + int'($urandom % 2);
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      if ($urandom % 2) do_write("R6 random write", addr, code, n, -1);
      else              do_read("R7 random read", addr, code, n, -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule